// File: doc/BRIEF.md
# Per-Tile CHR Bank Latch with Shadow Nametable RAM

This block gives every background tile its own 2 kB character bank. A small shadow RAM, one 6-bit entry per nametable cell, is filled whenever the video processor writes into the second nametable page ($2400-$27FF). Writes to the other pages do not reach it. Later, whenever the video processor reads a nametable cell from any of the four pages, the shadow entry at the same cell index is captured into a bank latch. That latched value then drives the upper character-ROM address bits for the pattern fetches of that tile, so both bitplanes of the tile come from the same bank.

The RAM select, the RAM write enable and the latch strobe are decoded from video address bits 13 and 10 and from the read and write strobes. The latch captures on the rising edge of its strobe, sampled on the system clock, and holds its value until the next nametable read. The bank outputs are driven only while the high program bank mode is active. Otherwise they read zero and the enable flag is low. The latch keeps tracking reads in both modes.

Top module: `exram_tile_bank`

## Requirements
- R1: A synchronous reset clears the bank latch, so that after reset bank_o reads 0 while hi_mode is 1.
- R2: A write (ppu_we_n low) with ppu_addr[13]=1 and ppu_addr[10]=1 stores ppu_data[5:0] into the shadow entry at ppu_addr[9:0]. Data bits 7:6 are discarded.
- R3: A write with ppu_addr[10]=0 or ppu_addr[13]=0 leaves every shadow entry unchanged.
- R4: The latch strobe is active when ppu_rd_n is low, ppu_addr[13] is high, and ppu_we_n or ppu_addr[10] is high. In the first cycle the strobe is active, the latch captures the shadow entry at ppu_addr[9:0]. The value appears on bank_o after that clock edge.
- R5: A read at the same ppu_addr[9:0] in any of the pages $2000, $2400, $2800 or $2C00 yields the same shadow entry.
- R6: Pattern fetches (ppu_addr[13]=0) do not change the latch, so both bitplane fetches of a tile see the same bank.
- R7: While the strobe stays active over several cycles, the latch captures only at the first cycle. Address changes during the hold have no effect.
- R8: With hi_mode=0, bank_o is 0 and bank_oe is 0. The latch still updates, and raising hi_mode shows the latched value in the same cycle, with bank_oe=1.
- R9: When a shadow write and a strobe start hit the same entry in one cycle, the latch receives the entry's previous content and the RAM receives the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ppu_addr | input | 14 | Video processor address bus |
| ppu_rd_n | input | 1 | Video read strobe, active low |
| ppu_we_n | input | 1 | Video write strobe, active low |
| ppu_data | input | 8 | Video write data |
| hi_mode | input | 1 | High program bank mode; enables the bank outputs |
| bank_o | output | 6 | Selected 2 kB character bank for the current tile |
| bank_oe | output | 1 | High while bank_o is driven |

## Verification
The bench writes to pages other than $2400, where a decoder that ignores bit 10 would corrupt the shadow entries. It holds a read strobe low across an address change, which exposes a level-sensitive latch that recaptures. It issues a write and a strobe start to the same entry in one cycle: a write-first RAM would hand the new data to the latch. It also switches the mode while reads continue, catching a design that freezes the latch in mode 0 or leaks the latch onto the outputs when disabled.

// File: rtl/exram_pkg.sv
package exram_pkg;

    localparam int PPU_AW     = 14;
    localparam int PPU_DW     = 8;
    localparam int NT_IDX_W   = 10;
    localparam int CHR_BANK_W = 6;
    localparam int BIT_PAGE   = 10;
    localparam int BIT_NT     = 13;

    typedef struct packed {
        logic cs_n;     // shadow RAM select, active low
        logic we_n;     // shadow RAM write enable, follows bus write strobe
        logic strobe;   // bank latch strobe, active high
    } exram_ctl_t;

    function automatic exram_ctl_t decode_ctl(
        input logic a_nt,
        input logic a_page,
        input logic rd_n,
        input logic we_n
    );
        exram_ctl_t c;
        c.cs_n   = !(a_nt && (we_n || a_page));
        c.we_n   = we_n;
        c.strobe = !rd_n && a_nt && (we_n || a_page);
        return c;
    endfunction

endpackage

// File: rtl/exram_decode.sv
module exram_decode
    import exram_pkg::*;
(
    input  logic       a_nt,
    input  logic       a_page,
    input  logic       rd_n,
    input  logic       we_n,
    output exram_ctl_t ctl,
    output logic       ram_wr
);

    always_comb begin
        ctl    = decode_ctl(a_nt, a_page, rd_n, we_n);
        ram_wr = !ctl.cs_n && !ctl.we_n;
    end

endmodule

// File: rtl/exram_store.sv
module exram_store #(
    parameter int IDX_W  = 10,
    parameter int BANK_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] rdata
);

    localparam int DEPTH = 1 << IDX_W;

    logic [BANK_W-1:0] mem_q [DEPTH];

    // read returns the content before any write at this edge
    assign rdata = mem_q[idx];

    always_ff @(posedge clk) begin
        if (wr) begin
            mem_q[idx] <= wdata;
        end
    end

    // R2
    wr_persist_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> (mem_q[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/exram_bank_latch.sv
module exram_bank_latch #(
    parameter int BANK_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic              mode,
    output logic [BANK_W-1:0] bank_o,
    output logic              bank_oe
);

    logic              strb_q;
    logic [BANK_W-1:0] lat_q;
    logic              capture;

    assign capture = strobe && !strb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strb_q <= 1'b0;
            lat_q  <= '0;
        end else begin
            strb_q <= strobe;
            if (capture) begin
                lat_q <= rd_bank;
            end
        end
    end

    generate
        for (genvar b = 0; b < BANK_W; b++) begin : g_gate
            assign bank_o[b] = lat_q[b] & mode;
        end
    endgenerate
    assign bank_oe = mode;

    // R4
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && !strb_q) |=> (lat_q == $past(rd_bank)));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(strobe && !strb_q) |=> $stable(lat_q));

    // R8
    off_chk: assert property (@(posedge clk) disable iff (rst)
        !mode |-> (bank_o == '0 && !bank_oe));

    // R8
    on_chk: assert property (@(posedge clk) disable iff (rst)
        mode |-> (bank_o == lat_q && bank_oe));

endmodule

// File: rtl/exram_tile_bank.sv
module exram_tile_bank
    import exram_pkg::*;
#(
    parameter int AW     = PPU_AW,
    parameter int DW     = PPU_DW,
    parameter int IDX_W  = NT_IDX_W,
    parameter int BANK_W = CHR_BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     ppu_addr,
    input  logic              ppu_rd_n,
    input  logic              ppu_we_n,
    input  logic [DW-1:0]     ppu_data,
    input  logic              hi_mode,
    output logic [BANK_W-1:0] bank_o,
    output logic              bank_oe
);

    exram_ctl_t        ctl;
    logic              ram_wr;
    logic [IDX_W-1:0]  idx;
    logic [BANK_W-1:0] rd_bank;
    logic              unused_bits;

    assign idx         = ppu_addr[IDX_W-1:0];
    assign unused_bits = ^{ppu_addr[AW-1:IDX_W], ppu_data[DW-1:BANK_W]};

    exram_decode i_decode (
        .a_nt   (ppu_addr[BIT_NT]),
        .a_page (ppu_addr[BIT_PAGE]),
        .rd_n   (ppu_rd_n),
        .we_n   (ppu_we_n),
        .ctl    (ctl),
        .ram_wr (ram_wr)
    );

    exram_store #(.IDX_W(IDX_W), .BANK_W(BANK_W)) i_store (
        .clk   (clk),
        .rst   (rst),
        .wr    (ram_wr),
        .idx   (idx),
        .wdata (ppu_data[BANK_W-1:0]),
        .rdata (rd_bank)
    );

    exram_bank_latch #(.BANK_W(BANK_W)) i_latch (
        .clk     (clk),
        .rst     (rst),
        .strobe  (ctl.strobe),
        .rd_bank (rd_bank),
        .mode    (hi_mode),
        .bank_o  (bank_o),
        .bank_oe (bank_oe)
    );

    // R3
    wr_page_chk: assert property (@(posedge clk) disable iff (rst)
        ram_wr |-> (ppu_addr[BIT_NT] && ppu_addr[BIT_PAGE] && !ppu_we_n));

    // R4
    strobe_sel_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.strobe |-> !ctl.cs_n);

    // R6
    pattern_chk: assert property (@(posedge clk) disable iff (rst)
        !ppu_addr[BIT_NT] |-> !ctl.strobe);

endmodule

// File: tb/test_exram_tile_bank.sv
module test_exram_tile_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] ppu_addr = '0;
    logic        ppu_rd_n = 1'b1;
    logic        ppu_we_n = 1'b1;
    logic [7:0]  ppu_data = '0;
    logic        hi_mode = 1'b1;
    logic [5:0]  bank_o;
    logic        bank_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    exram_tile_bank i_exram_tile_bank (
        .clk      (clk),
        .rst      (rst),
        .ppu_addr (ppu_addr),
        .ppu_rd_n (ppu_rd_n),
        .ppu_we_n (ppu_we_n),
        .ppu_data (ppu_data),
        .hi_mode  (hi_mode),
        .bank_o   (bank_o),
        .bank_oe  (bank_oe)
    );

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic idle();
        ppu_addr = 14'h0000;
        ppu_rd_n = 1'b1;
        ppu_we_n = 1'b1;
    endtask

    task automatic nt_write(input logic [13:0] a, input logic [7:0] d);
        @(negedge clk);
        ppu_addr = a; ppu_data = d; ppu_we_n = 1'b0; ppu_rd_n = 1'b1;
        @(negedge clk);
        idle();
    endtask

    task automatic nt_read(input logic [13:0] a);
        @(negedge clk);
        ppu_addr = a; ppu_rd_n = 1'b0; ppu_we_n = 1'b1;
        @(negedge clk);
        idle();
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 bank after reset", bank_o, 0);
        chk("R1 oe after reset", bank_oe, 1);
    endtask

    task automatic t_write_read();
        nt_write(14'h2405, 8'hC7);
        nt_read(14'h2005);
        chk("R2 R4 masked write then read", bank_o, 6'h07);
        nt_write(14'h27FF, 8'h3E);
        nt_read(14'h2FFF);
        chk("R4 last entry", bank_o, 6'h3E);
    endtask

    task automatic t_alias();
        nt_write(14'h2410, 8'h2A);
        nt_read(14'h2010);
        chk("R5 page 2000", bank_o, 6'h2A);
        nt_read(14'h2005);
        nt_read(14'h2410);
        chk("R5 page 2400", bank_o, 6'h2A);
        nt_read(14'h2005);
        nt_read(14'h2810);
        chk("R5 page 2800", bank_o, 6'h2A);
        nt_read(14'h2005);
        nt_read(14'h2C10);
        chk("R5 page 2C00", bank_o, 6'h2A);
    endtask

    task automatic t_nowrite();
        nt_write(14'h2005, 8'h3F);
        nt_write(14'h0405, 8'h11);
        nt_write(14'h2805, 8'h22);
        nt_read(14'h2405);
        chk("R3 entry untouched by other pages", bank_o, 6'h07);
    endtask

    task automatic t_pattern();
        nt_read(14'h2010);
        @(negedge clk);
        ppu_addr = 14'h0100; ppu_rd_n = 1'b0;
        @(negedge clk);
        chk("R6 bitplane 0", bank_o, 6'h2A);
        ppu_addr = 14'h0108;
        @(negedge clk);
        chk("R6 bitplane 1", bank_o, 6'h2A);
        idle();
    endtask

    task automatic t_hold();
        nt_write(14'h2420, 8'h15);
        nt_write(14'h2421, 8'h33);
        @(negedge clk);
        ppu_addr = 14'h2420; ppu_rd_n = 1'b0;
        @(negedge clk);
        chk("R7 first capture", bank_o, 6'h15);
        ppu_addr = 14'h2421;
        @(negedge clk);
        @(negedge clk);
        chk("R7 no recapture while held", bank_o, 6'h15);
        idle();
        nt_read(14'h2421);
        chk("R7 new strobe captures", bank_o, 6'h33);
    endtask

    task automatic t_mode();
        @(negedge clk);
        hi_mode = 1'b0;
        #1;
        chk("R8 bank off", bank_o, 0);
        chk("R8 oe off", bank_oe, 0);
        nt_read(14'h2010);
        chk("R8 still off after read", bank_o, 0);
        @(negedge clk);
        hi_mode = 1'b1;
        #1;
        chk("R8 latch tracked in mode 0", bank_o, 6'h2A);
        chk("R8 oe on", bank_oe, 1);
    endtask

    task automatic t_collide();
        nt_write(14'h2430, 8'h0C);
        nt_read(14'h2005);
        @(negedge clk);
        ppu_addr = 14'h2430; ppu_rd_n = 1'b0; ppu_we_n = 1'b0; ppu_data = 8'h31;
        @(negedge clk);
        idle();
        chk("R9 latch gets old content", bank_o, 6'h0C);
        nt_read(14'h2430);
        chk("R9 RAM holds new data", bank_o, 6'h31);
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mid-run reset", bank_o, 0);
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write_read();
        t_alias();
        t_nowrite();
        t_pattern();
        t_hold();
        t_mode();
        t_collide();
        t_reset_mid();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule